// File: doc/BRIEF.md
# Cycle Timer with Countdown Interrupt

This block keeps two time counters for a processor core. A 64-bit up-counter advances at a fixed fraction of the core clock and serves as a monotonic time reference. A 32-bit down-counter runs at a rate set by the ratio between bus and core clocks, and raises a pending interrupt flag when it crosses into negative values.

Software reaches both counters through a small register port. One strobe writes the lower or upper half of the up-counter, or loads the down-counter. A separate select picks what the registered read data returns on the next cycle. A two-bit pending vector carries the countdown event and an external interrupt line. Each bit stays set until software acknowledges it.

The two counters have separate prescalers. A write to either half of the up-counter restarts its prescaler. A load of the down-counter leaves its prescaler phase untouched. A load can itself raise the countdown flag.

Top module: `cycle_timer_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the up-counter, the down-counter, both prescalers, `pending` and `rd_data` are cleared. After reset, every readable register returns zero until it changes.
- R2: With no write, the 64-bit up-counter increases by exactly one every `TB_DIV` (default 4) clock cycles. The first increment comes `TB_DIV` edges after reset is released.
- R3: A write with `wr_sel` = 0 replaces bits 31:0 of the up-counter with `wr_data` and keeps bits 63:32.
- R4: A write with `wr_sel` = 1 replaces bits 63:32 of the up-counter with `wr_data` and keeps bits 31:0.
- R5: A write to either up-counter half restarts its prescaler. The next increment comes exactly `TB_DIV` edges after the write edge.
- R6: With no load, the 32-bit down-counter decreases by one every 2 × `BUS_MULT` clock cycles.
- R7: A load of the down-counter (`wr_sel` = 2) sets its value but does not disturb the prescaler phase. Later decrements stay on the grid set up at reset.
- R8: A load sets `pending[1]` when the loaded value has bit 31 set and the current value has bit 31 clear. A load with bit 31 set over a value that already has bit 31 set does not set it.
- R9: A load of exactly zero sets `pending[1]`.
- R10: A decrement from 0 to 0xFFFFFFFF sets `pending[1]`.
- R11: A high `ext_irq` on a clock edge sets `pending[0]`.
- R12: A pending bit stays set until the matching `ack` bit is 1 on an edge. If a set and an acknowledge arrive on the same edge, the set wins.
- R13: `rd_data` is registered and shows the register picked by `rd_sel` as it was before that edge: 0 = up-counter low, 1 = up-counter high, 2 = down-counter. Select 3 reads zero, and writes to select 3 change nothing.
- R14: An increment of the up-counter with the low half at 0xFFFFFFFF carries into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 up-counter low, 1 up-counter high, 2 down-counter, 3 none |
| wr_data | input | DATA_W | Write value |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | DATA_W | Registered read value |
| ext_irq | input | 1 | External interrupt request, sets `pending[0]` |
| ack | input | 2 | Write-one-to-clear acknowledge for `pending` |
| pending | output | 2 | Bit 1 countdown event, bit 0 external request |

## Verification
The bench builds the block with `BUS_MULT` = 3, so the down-counter steps every six cycles and the up-counter every four. Their phases drift apart, and a prescaler that one write restarts while the other keeps its phase shows up within a few loads. `TB_DIV` stays at four.

The bench loads values near the up-counter's carry boundary and near zero on the down-counter. This reaches the 32-bit carry, the wrap to all ones and the sign-bit load rule within a few dozen cycles.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  typedef enum logic [1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int PEND_EXT = 0;
  localparam int PEND_DEC = 1;
  localparam int PEND_W   = 2;
endpackage

// File: rtl/ctu_prescaler.sv
module ctu_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || restart) ph <= '0;
    else if (ph == LAST) ph <= '0;
    else ph <= ph + 1'b1;
  end

  assign tick = (ph == LAST) && !restart;

  assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
    (ph != LAST) |=> (ph == $past(ph) + 1'b1) || $past(restart));
endmodule

// File: rtl/ctu_timebase.sv
module ctu_timebase #(
  parameter int HALF_W = 32,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  output logic [2*HALF_W-1:0] tb_q
);
  localparam int TB_W = 2 * HALF_W;

  logic tick;
  logic wr_any;

  assign wr_any = wr_lo || wr_hi;

  ctu_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_any), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) tb_q <= '0;
    else if (wr_lo) tb_q[HALF_W-1:0] <= wr_data;
    else if (wr_hi) tb_q[TB_W-1:HALF_W] <= wr_data;
    else if (tick) tb_q <= tb_q + 1'b1;
  end

  assert_lo_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (tb_q[TB_W-1:HALF_W] == $past(tb_q[TB_W-1:HALF_W])) &&
              (tb_q[HALF_W-1:0] == $past(wr_data)));

  assert_hi_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (tb_q[HALF_W-1:0] == $past(tb_q[HALF_W-1:0])) &&
                          (tb_q[TB_W-1:HALF_W] == $past(wr_data)));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_any |=> (tb_q == $past(tb_q)) || (tb_q == $past(tb_q) + 1'b1));
endmodule

// File: rtl/ctu_decrementer.sv
module ctu_decrementer #(
  parameter int W   = 32,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dec_q,
  output logic         set_evt
);
  logic tick;
  logic load_evt;
  logic wrap_evt;

  ctu_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .restart(1'b0), .tick(tick)
  );

  assign load_evt = (wr_data[W-1] && !dec_q[W-1]) || (wr_data == '0);
  assign wrap_evt = tick && (dec_q == '0);
  assign set_evt  = wr ? load_evt : wrap_evt;

  always_ff @(posedge clk) begin
    if (rst) dec_q <= '0;
    else if (wr) dec_q <= wr_data;
    else if (tick) dec_q <= dec_q - 1'b1;
  end

  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (dec_q == $past(dec_q)) || (dec_q == $past(dec_q) - 1'b1));

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    wr |=> dec_q == $past(wr_data));

  assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr && dec_q == '0) |=> (dec_q == '0) || $past(set_evt));
endmodule

// File: rtl/cycle_timer_unit.sv
module cycle_timer_unit #(
  parameter int DATA_W   = 32,
  parameter int TB_DIV   = 4,
  parameter int BUS_MULT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_irq,
  input  logic [1:0]        ack,
  output logic [1:0]        pending
);
  import ctu_pkg::*;

  localparam int DEC_DIV = 2 * BUS_MULT;
  localparam int TB_W    = 2 * DATA_W;

  logic              wr_lo, wr_hi, wr_dec;
  logic [TB_W-1:0]   tb_q;
  logic [DATA_W-1:0] dec_q;
  logic              dec_evt;
  logic [DATA_W-1:0] rd_next;
  logic [PEND_W-1:0] set_vec;

  assign wr_lo  = wr_en && (reg_sel_e'(wr_sel) == SEL_TB_LO);
  assign wr_hi  = wr_en && (reg_sel_e'(wr_sel) == SEL_TB_HI);
  assign wr_dec = wr_en && (reg_sel_e'(wr_sel) == SEL_DEC);

  ctu_timebase #(.HALF_W(DATA_W), .DIV(TB_DIV)) u_tb (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .tb_q(tb_q)
  );

  ctu_decrementer #(.W(DATA_W), .DIV(DEC_DIV)) u_dec (
    .clk(clk), .rst(rst), .wr(wr_dec), .wr_data(wr_data),
    .dec_q(dec_q), .set_evt(dec_evt)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_TB_LO: rd_next = tb_q[DATA_W-1:0];
      SEL_TB_HI: rd_next = tb_q[TB_W-1:DATA_W];
      SEL_DEC:   rd_next = dec_q;
      default:   rd_next = '0;
    endcase
  end

  always_comb begin
    set_vec           = '0;
    set_vec[PEND_EXT] = ext_irq;
    set_vec[PEND_DEC] = dec_evt;
  end

  genvar gi;
  generate
    for (gi = 0; gi < PEND_W; gi++) begin : g_pend
      always_ff @(posedge clk) begin
        if (rst) pending[gi] <= 1'b0;
        else pending[gi] <= (pending[gi] && !ack[gi]) || set_vec[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else rd_data <= rd_next;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pending == '0) && (rd_data == '0));

  assert_zero_load_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_dec && wr_data == '0) |=> pending[PEND_DEC]);

  assert_evt_sets_R10: assert property (@(posedge clk) disable iff (rst)
    dec_evt |=> pending[PEND_DEC]);

  assert_ext_R11: assert property (@(posedge clk) disable iff (rst)
    ext_irq |=> pending[PEND_EXT]);

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (pending[PEND_DEC] && !ack[PEND_DEC]) |=> pending[PEND_DEC]);

  assert_none_reads_zero_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 2'd3) |=> rd_data == '0);
endmodule

// File: tb/sim_cycle_timer_unit.sv
`timescale 1ns/1ps
module sim_cycle_timer_unit;
  localparam int BM = 3;
  localparam int DP = 2 * BM;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        ext_irq = 1'b0;
  logic [1:0]  ack = 2'b00;
  logic [1:0]  pending;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [63:0] m_tb;
  int          m_tbph;
  logic [31:0] m_dec;
  int          m_decph;
  logic [1:0]  m_pend;
  logic [31:0] m_rd;

  always #2 clk = ~clk;

  cycle_timer_unit #(.DATA_W(32), .TB_DIV(4), .BUS_MULT(BM)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ext_irq(ext_irq), .ack(ack),
    .pending(pending)
  );

  task automatic model_edge();
    logic dec_set;
    logic tick;
    if (rst) begin
      m_tb = '0; m_tbph = 0; m_dec = '0; m_decph = 0; m_pend = '0; m_rd = '0;
      return;
    end
    case (rd_sel)
      2'd0: m_rd = m_tb[31:0];
      2'd1: m_rd = m_tb[63:32];
      2'd2: m_rd = m_dec;
      default: m_rd = '0;
    endcase
    if (wr_en && wr_sel == 2'd0) begin
      m_tb[31:0] = wr_data; m_tbph = 0;
    end else if (wr_en && wr_sel == 2'd1) begin
      m_tb[63:32] = wr_data; m_tbph = 0;
    end else if (m_tbph == 3) begin
      m_tb = m_tb + 64'd1; m_tbph = 0;
    end else m_tbph++;
    dec_set = 1'b0;
    tick = (m_decph == DP - 1);
    m_decph = tick ? 0 : m_decph + 1;
    if (wr_en && wr_sel == 2'd2) begin
      dec_set = (wr_data[31] && !m_dec[31]) || (wr_data == 32'd0);
      m_dec = wr_data;
    end else if (tick) begin
      if (m_dec == 32'd0) dec_set = 1'b1;
      m_dec = m_dec - 32'd1;
    end
    m_pend[1] = (m_pend[1] && !ack[1]) || dec_set;
    m_pend[0] = (m_pend[0] && !ack[0]) || ext_irq;
  endtask

  task automatic compare();
    checks++;
    if (rd_data !== m_rd) begin
      failures++;
      $display("FAIL %s rd_data sel=%0d actual=%h expected=%h", cur_req, rd_sel, rd_data, m_rd);
    end
    checks++;
    if (pending !== m_pend) begin
      failures++;
      $display("FAIL %s pending actual=%b expected=%b", cur_req, pending, m_pend);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] ws, input logic [31:0] wd,
                     input logic [1:0] rs, input logic ex, input logic [1:0] ak);
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs; ext_irq = ex; ack = ak;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input logic [1:0] rs);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd3, 32'd0, rs, 1'b0, 2'b00);
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1";
    rst = 1'b1;
    idle(3, 2'd0);
    rst = 1'b0;
    idle(1, 2'd1);
    idle(1, 2'd2);
    idle(1, 2'd3);
    cur_req = "R2";
    idle(12, 2'd0);
    cur_req = "R3";
    cyc(1'b1, 2'd0, 32'hFFFF_FFFC, 2'd0, 1'b0, 2'b00);
    idle(2, 2'd1);
    cur_req = "R14";
    for (int i = 0; i < 18; i++) idle(1, (i % 2 == 0) ? 2'd0 : 2'd1);
    cur_req = "R4";
    cyc(1'b1, 2'd1, 32'h1234_5678, 2'd0, 1'b0, 2'b00);
    for (int i = 0; i < 6; i++) idle(1, (i % 2 == 0) ? 2'd1 : 2'd0);
    cur_req = "R5";
    idle(1, 2'd0);
    cyc(1'b1, 2'd0, 32'h0000_0100, 2'd0, 1'b0, 2'b00);
    idle(9, 2'd0);
    idle(2, 2'd0);
    cyc(1'b1, 2'd1, 32'h0000_0001, 2'd0, 1'b0, 2'b00);
    idle(7, 2'd0);
    cur_req = "R6";
    cyc(1'b1, 2'd2, 32'h0000_0010, 2'd2, 1'b0, 2'b00);
    idle(26, 2'd2);
    cur_req = "R7";
    for (int k = 0; k < 5; k++) begin
      idle(k + 1, 2'd2);
      cyc(1'b1, 2'd2, 32'h0000_0040 + k, 2'd2, 1'b0, 2'b00);
    end
    idle(14, 2'd2);
    cur_req = "R8";
    cyc(1'b1, 2'd2, 32'h8000_0005, 2'd2, 1'b0, 2'b00);
    idle(3, 2'd2);
    cyc(1'b0, 2'd3, 32'd0, 2'd2, 1'b0, 2'b10);
    idle(2, 2'd2);
    cyc(1'b1, 2'd2, 32'h8000_0001, 2'd2, 1'b0, 2'b00);
    idle(4, 2'd2);
    cur_req = "R12";
    cyc(1'b1, 2'd2, 32'h0000_0030, 2'd2, 1'b0, 2'b00);
    cyc(1'b1, 2'd2, 32'h9000_0000, 2'd2, 1'b0, 2'b00);
    idle(5, 2'd2);
    cyc(1'b1, 2'd2, 32'h0000_0000, 2'd2, 1'b0, 2'b10);
    idle(2, 2'd2);
    cyc(1'b0, 2'd3, 32'd0, 2'd2, 1'b0, 2'b10);
    idle(3, 2'd2);
    cur_req = "R9";
    cyc(1'b1, 2'd2, 32'h0000_0000, 2'd2, 1'b0, 2'b00);
    idle(2, 2'd2);
    cyc(1'b0, 2'd3, 32'd0, 2'd2, 1'b0, 2'b10);
    idle(3, 2'd2);
    cur_req = "R10";
    cyc(1'b0, 2'd3, 32'd0, 2'd2, 1'b0, 2'b10);
    cyc(1'b1, 2'd2, 32'h0000_0002, 2'd2, 1'b0, 2'b10);
    idle(24, 2'd2);
    cur_req = "R11";
    cyc(1'b0, 2'd3, 32'd0, 2'd0, 1'b1, 2'b00);
    idle(4, 2'd0);
    cyc(1'b0, 2'd3, 32'd0, 2'd0, 1'b0, 2'b01);
    idle(2, 2'd0);
    cyc(1'b0, 2'd3, 32'd0, 2'd0, 1'b1, 2'b01);
    idle(2, 2'd0);
    cyc(1'b0, 2'd3, 32'd0, 2'd0, 1'b0, 2'b11);
    idle(2, 2'd0);
    cur_req = "R13";
    cyc(1'b1, 2'd3, 32'hDEAD_BEEF, 2'd3, 1'b0, 2'b00);
    idle(1, 2'd3);
    idle(1, 2'd0);
    idle(1, 2'd1);
    idle(1, 2'd2);
    cyc(1'b1, 2'd3, 32'h0000_0000, 2'd2, 1'b0, 2'b00);
    idle(8, 2'd2);
    cur_req = "R1";
    rst = 1'b1;
    idle(2, 2'd1);
    rst = 1'b0;
    idle(1, 2'd0);
    idle(1, 2'd2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule